// File: doc/BRIEF.md
# DDR3 Refresh Cadence Monitor

This block observes the command stream that a DDR3 controller sends after initialization and checks that refresh is kept on schedule. Each clock it samples a pre-decoded command code (refresh, NOP or anything else), the clock-enable level and a level flag that says initialization is complete. It keeps two counters. One counts clocks since the last refresh. The other tracks how far the controller has got through a postponed refresh burst. When the controller breaks a rule, the block latches a sticky violation together with a two-bit cause. The cause stays put until reset.

The deadline is not a fixed per-refresh interval. Refreshes may be postponed and then issued back to back. So the largest allowed gap is derived as `NREF*REFI - (NREF-1)*RFC` clocks. With the defaults (REFI = 1560 clocks, which is 7.8 us at 200 MHz, RFC = 320 and NREF = 4) this is 5280 clocks.

A refresh that arrives outside a burst opens a burst with the burst count set to 0. Each later refresh advances the count. The burst closes when the count reaches NREF. Until then only refresh and NOP are legal, and the deadline is not judged.

The monitor is a four-state machine:
- **OFF** (monitoring idle). It moves to STEADY when `init_done` is high. On that edge it clears the gap counter and presets the burst count to NREF.
- **STEADY** (operating, no burst). It moves to BURST on a refresh. It moves to OFF when `init_done` falls. It moves to FAULT on low clock enable or on an expired deadline.
- **BURST** (operating, inside a burst). It moves back to STEADY on the refresh that completes the burst. It moves to OFF when `init_done` falls. It moves to FAULT on low clock enable or on any command other than NOP or refresh.
- **FAULT** is left only by reset.

Top module: `refresh_cadence_monitor`

## Requirements
- R1: After reset `mon_active` = 0, `viol` = 0 and `viol_cause` = 2'b00 (no violation).
- R2: While the block is in OFF, a high `init_done` sampled at a clock edge makes `mon_active` = 1 after that edge, with the gap counter at 0.
- R3: Outside a burst, the gap counter advances by one on each edge that carries a command other than refresh (`cmd` 2'b00 NOP, 2'b10 and 2'b11 other). If the gap counter reaches REFI*NREF-(NREF-1)*RFC (5280 by default), `viol` = 1 with `viol_cause` = 2'b01 (deadline). One edge fewer leaves `viol` = 0.
- R4: Every refresh (`cmd` = 2'b01) clears the gap counter.
- R5: A refresh outside a burst starts a burst at count 0, and each further refresh adds one. While the count is below NREF, a command coded 2'b10 or 2'b11 gives `viol` = 1 with `viol_cause` = 2'b10 (illegal command in burst). NOP is legal in a burst.
- R6: Once NREF refreshes have followed the burst-opening one, the burst is complete and other commands are legal again.
- R7: `cke` = 0 while `mon_active` = 1 and `init_done` = 1 gives `viol` = 1 with `viol_cause` = 2'b11. `cke` = 0 while monitoring is idle has no effect.
- R8: When a low `cke` falls in the same edge as an illegal burst command or an expiring deadline, the reported cause is 2'b11.
- R9: A violation is sticky. `viol` stays 1 and `viol_cause` stays unchanged until `rst_n` is asserted, and `mon_active` is 0 while the violation is held, whatever the inputs.
- R10: `init_done` low while monitoring returns the block to idle (`mon_active` = 0) without a violation, even mid-burst. Re-entry presets the burst count to NREF, so non-refresh commands are legal at once.
- R11: The deadline is not judged inside a burst. NOPs for longer than the deadline during a burst give no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Level: DRAM initialization is complete, monitoring enabled |
| cke | input | 1 | Sampled clock-enable level of the DRAM |
| cmd | input | 2 | Decoded command: 00 NOP, 01 refresh, 10/11 any other |
| mon_active | output | 1 | Monitor is in STEADY or BURST |
| viol | output | 1 | Sticky violation flag |
| viol_cause | output | 2 | 00 none, 01 deadline, 10 illegal command in burst, 11 clock enable dropped |

## Verification
The clock-enable check can coincide with the other two fault detectors. A low `cke` can land on the same edge as an illegal command inside a burst, or on the very edge at which the gap counter would reach the deadline. The bench provokes both cases: it drops `cke` together with a non-NOP command right after a burst opens, and again on the 5280th non-refresh edge after entry. In both cases the latched cause must be 2'b11, not the burst or deadline code. The bench also drives a refresh on the edge just before expiry, to show that the refresh path wins over the deadline.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    localparam logic [1:0] CMD_NOP = 2'b00;
    localparam logic [1:0] CMD_REF = 2'b01;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'b00,
        CAUSE_DEADLINE  = 2'b01,
        CAUSE_BURST_CMD = 2'b10,
        CAUSE_CKE       = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_STEADY = 2'b01,
        ST_BURST  = 2'b10,
        ST_FAULT  = 2'b11
    } mon_state_e;

endpackage

// File: rtl/rcm_gap_timer.sv
module rcm_gap_timer #(
    parameter int LIMIT = 5280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic expire_next
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V  = W'(LIMIT);
    localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt < LIM_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // one more advance would reach the limit
    assign expire_next = (cnt >= LAST_V);

endmodule

// File: rtl/rcm_burst_tracker.sv
module rcm_burst_tracker #(
    parameter int NREF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset,
    input  logic restart,
    input  logic adv,
    output logic last
);
    localparam int W = $clog2(NREF + 1);
    localparam logic [W-1:0] FULL_V = W'(NREF);
    localparam logic [W-1:0] LAST_V = W'(NREF - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= FULL_V;
        end else if (preset) begin
            cnt <= FULL_V;
        end else if (restart) begin
            cnt <= '0;
        end else if (adv && (cnt < FULL_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // the next refresh fills the burst
    assign last = (cnt == LAST_V);

endmodule

// File: rtl/refresh_cadence_monitor.sv
module refresh_cadence_monitor
    import rcm_pkg::*;
#(
    parameter int REFI = 1560,
    parameter int RFC  = 320,
    parameter int NREF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_done,
    input  logic       cke,
    input  logic [1:0] cmd,
    output logic       mon_active,
    output logic       viol,
    output logic [1:0] viol_cause
);
    localparam int GAP_LIMIT = NREF * REFI - (NREF - 1) * RFC;

    mon_state_e st, st_n;
    cause_e     cause_q, fault_code;

    logic gap_clr, gap_inc, gap_expire;
    logic b_preset, b_restart, b_adv, b_last;

    rcm_gap_timer #(.LIMIT(GAP_LIMIT)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (gap_clr),
        .inc        (gap_inc),
        .expire_next(gap_expire)
    );

    rcm_burst_tracker #(.NREF(NREF)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (b_preset),
        .restart(b_restart),
        .adv    (b_adv),
        .last   (b_last)
    );

    // state register and latched cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_OFF;
            cause_q <= CAUSE_NONE;
        end else begin
            st <= st_n;
            if ((st != ST_FAULT) && (st_n == ST_FAULT)) begin
                cause_q <= fault_code;
            end
        end
    end

    // transitions and counter controls
    always_comb begin
        st_n       = st;
        fault_code = CAUSE_NONE;
        gap_clr    = 1'b0;
        gap_inc    = 1'b0;
        b_preset   = 1'b0;
        b_restart  = 1'b0;
        b_adv      = 1'b0;
        unique case (st)
            ST_OFF: begin
                if (init_done) begin
                    st_n     = ST_STEADY;
                    gap_clr  = 1'b1;
                    b_preset = 1'b1;
                end
            end
            ST_STEADY: begin
                if (!init_done) begin
                    st_n = ST_OFF;
                end else if (!cke) begin
                    st_n       = ST_FAULT;
                    fault_code = CAUSE_CKE;
                end else if (cmd == CMD_REF) begin
                    st_n      = ST_BURST;
                    gap_clr   = 1'b1;
                    b_restart = 1'b1;
                end else if (gap_expire) begin
                    st_n       = ST_FAULT;
                    fault_code = CAUSE_DEADLINE;
                end else begin
                    gap_inc = 1'b1;
                end
            end
            ST_BURST: begin
                if (!init_done) begin
                    st_n = ST_OFF;
                end else if (!cke) begin
                    st_n       = ST_FAULT;
                    fault_code = CAUSE_CKE;
                end else if (cmd == CMD_REF) begin
                    gap_clr = 1'b1;
                    b_adv   = 1'b1;
                    if (b_last) begin
                        st_n = ST_STEADY;
                    end
                end else if (cmd == CMD_NOP) begin
                    gap_inc = 1'b1;
                end else begin
                    st_n       = ST_FAULT;
                    fault_code = CAUSE_BURST_CMD;
                end
            end
            ST_FAULT: begin
                st_n = ST_FAULT;
            end
        endcase
    end

    // outputs
    always_comb begin
        mon_active = (st == ST_STEADY) || (st == ST_BURST);
        viol       = (st == ST_FAULT);
        viol_cause = cause_q;
    end

endmodule

// File: rtl/rcm_checker.sv
module rcm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       init_done,
    input logic       cke,
    input logic [1:0] cmd,
    input logic       mon_active,
    input logic       viol,
    input logic [1:0] viol_cause
);
    // R9: violation and its cause hold
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> (viol && $stable(viol_cause)));

    // R9: no monitoring while a fault is held
    p_fault_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> !mon_active);

    // R1: flag and cause agree
    p_cause_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        viol == (viol_cause != 2'b00));

    // R2: entry into monitoring
    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_active && !viol && init_done) |=> mon_active);

    // R7: clock enable dropped while monitoring
    p_cke_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_active && init_done && !cke) |=> (viol && viol_cause == 2'b11));

    // R10: leaving monitoring is quiet
    p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_active && !init_done) |=> (!mon_active && !viol));

    // R3: a deadline fault never follows a refresh or a low clock enable
    p_deadline_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(viol) && viol_cause == 2'b01) |-> ($past(cke) && $past(cmd) != 2'b01));

endmodule

bind refresh_cadence_monitor rcm_checker u_rcm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .cke       (cke),
    .cmd       (cmd),
    .mon_active(mon_active),
    .viol      (viol),
    .viol_cause(viol_cause)
);

// File: tb/refresh_cadence_monitor_test.sv
module refresh_cadence_monitor_test;

    localparam int LIMIT = 4 * 1560 - 3 * 320;   // 5280
    localparam logic [1:0] NOP = 2'b00, REF = 2'b01, OTH = 2'b10, OTH3 = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_done = 1'b0;
    logic       cke = 1'b1;
    logic [1:0] cmd = 2'b00;
    logic       mon_active, viol;
    logic [1:0] viol_cause;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    refresh_cadence_monitor uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .cke       (cke),
        .cmd       (cmd),
        .mon_active(mon_active),
        .viol      (viol),
        .viol_cause(viol_cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [1:0] c, input int n);
        cmd = c;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; init_done = 1'b0; cke = 1'b1; cmd = NOP;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic enter();
        init_done = 1'b1;
        cyc(NOP, 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mon_active", mon_active, 0);
        chk("R1 viol", viol, 0);
        chk("R1 cause", viol_cause, 0);
    endtask

    task automatic t_deadline();
        do_reset();
        enter();
        chk("R2 mon_active after init", mon_active, 1);
        cyc(OTH, LIMIT - 1);
        chk("R3 no fault one edge early", viol, 0);
        cyc(OTH3, 1);
        chk("R3 fault at deadline", viol, 1);
        chk("R3 cause deadline", viol_cause, 1);
    endtask

    task automatic t_refresh_clears();
        do_reset();
        enter();
        cyc(OTH, LIMIT - 2);
        cyc(REF, 5);
        chk("R4 refresh before expiry", viol, 0);
        cyc(OTH, LIMIT - 1);
        chk("R6 other legal after burst", viol, 0);
        chk("R4 still active", mon_active, 1);
        cyc(NOP, 1);
        chk("R4 deadline counted from last refresh", viol_cause, 1);
    endtask

    task automatic t_burst_short();
        do_reset();
        enter();
        cyc(REF, 4);
        chk("R5 burst open no fault", viol, 0);
        cyc(OTH3, 1);
        chk("R5 illegal in burst", viol, 1);
        chk("R5 cause burst", viol_cause, 2);
    endtask

    task automatic t_burst_full();
        do_reset();
        enter();
        cyc(REF, 1); cyc(NOP, 3); cyc(REF, 2); cyc(NOP, 2); cyc(REF, 2);
        chk("R5 nop legal in burst", viol, 0);
        cyc(OTH, 3);
        chk("R6 other legal after full burst", viol, 0);
    endtask

    task automatic t_burst_no_deadline();
        do_reset();
        enter();
        cyc(REF, 1);
        cyc(NOP, LIMIT + 5);
        chk("R11 no deadline in burst", viol, 0);
        cyc(REF, 4);
        cyc(OTH, 2);
        chk("R11 burst completes cleanly", viol, 0);
        chk("R11 active", mon_active, 1);
    endtask

    task automatic t_cke();
        do_reset();
        cke = 1'b0;
        cyc(OTH, 3);
        chk("R7 cke ignored while idle viol", viol, 0);
        chk("R7 cke ignored while idle active", mon_active, 0);
        cke = 1'b1;
        enter();
        cke = 1'b0;
        cyc(NOP, 1);
        chk("R7 cke fault", viol, 1);
        chk("R7 cause cke", viol_cause, 3);
    endtask

    task automatic t_priority();
        do_reset();
        enter();
        cyc(REF, 1);
        cke = 1'b0;
        cyc(OTH, 1);
        chk("R8 cke beats burst cmd", viol_cause, 3);
        // sticky behaviour on the same fault
        cke = 1'b1;
        cyc(REF, 3);
        init_done = 1'b0;
        cyc(OTH, 2);
        init_done = 1'b1;
        cyc(NOP, 2);
        chk("R9 viol held", viol, 1);
        chk("R9 cause held", viol_cause, 3);
        chk("R9 inactive in fault", mon_active, 0);
        do_reset();
        enter();
        cyc(OTH, LIMIT - 1);
        cke = 1'b0;
        cyc(OTH, 1);
        chk("R8 cke beats deadline", viol_cause, 3);
        cke = 1'b1;
    endtask

    task automatic t_exit();
        do_reset();
        enter();
        cyc(REF, 1);
        init_done = 1'b0;
        cyc(NOP, 1);
        chk("R10 idle after init low", mon_active, 0);
        chk("R10 no fault on exit", viol, 0);
        cyc(OTH, LIMIT + 5);
        chk("R10 idle no deadline", viol, 0);
        enter();
        cyc(OTH, 3);
        chk("R10 re-entry preset burst", viol, 0);
        chk("R10 re-entry active", mon_active, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_deadline();
        t_refresh_clears();
        t_burst_short();
        t_burst_full();
        t_burst_no_deadline();
        t_cke();
        t_priority();
        t_exit();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule